// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Busy-Guarded Reads

This block holds the bytes decoded by an infrared remote-control receiver until the CPU collects them. The decoder presents each finished byte with a one-cycle write strobe. A busy input from the decoder is high while a frame is on the air. Up to 18 bytes are kept in arrival order. The CPU drains them through a single data port: each read strobe returns the oldest byte still held.

Reads are honoured only while the receiver is idle. A read strobe that arrives while a frame is in progress, or while nothing is stored, yields a zero byte and leaves the stored contents and the byte count untouched. A byte that arrives when all 18 slots are full is dropped and raises a sticky overrun flag. An explicit clear input or reset releases that flag. The bytes already stored survive an overrun and stay readable.

A 16-bit configuration/status word packs three things. The live byte count sits in the top five bits and is read-only. The next bit is a reserved bit that always reads zero. The low ten bits hold a writable minimum-period setting, which is also driven out to the pulse-timing logic.

Top module: `ir_rx_byte_buf`

## Requirements
- R1: After synchronous reset the byte count is 0, the overrun flag is 0, the read data is 8'h00 and the period setting is 0.
- R2: A write strobe while fewer than 18 bytes are held stores the byte. Without a read in the same cycle, the count rises by one at the next clock edge.
- R3: The byte count never exceeds 18.
- R4: A write strobe while 18 bytes are held raises the overrun flag and drops the byte. The count stays at 18 and all earlier bytes stay readable.
- R5: A read strobe while busy is low and the count is non-zero delivers the oldest held byte on the read data one cycle later. It lowers the count by one. Bytes leave in arrival order, including across the wrap from slot 17 to slot 0.
- R6: A read strobe while busy is high delivers 8'h00. It changes neither the count nor the read position, so the next idle read returns the byte that would have been returned.
- R7: A read strobe while the count is 0 delivers 8'h00 and the count stays at 0.
- R8: The overrun flag stays set until the clear input is pulsed or reset is applied.
- R9: The configuration word reads as {count[4:0], 1'b0, period[9:0]}. A configuration write loads only bits 9:0 and ignores bits 15:10.
- R10: An idle read and a write in the same cycle, with 1 to 17 bytes held, both take effect and leave the count unchanged.
- R11: The read data holds its value between read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Frame reception in progress |
| wr_stb_i | input | 1 | Decoded byte strobe |
| wr_data_i | input | 8 | Decoded byte |
| rd_stb_i | input | 1 | CPU read of the shared data address |
| rd_data_o | output | 8 | Byte returned one cycle after a read strobe |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration/status word readback |
| period_o | output | 10 | Minimum-period setting for the timing logic |

## Verification
The bound checker covers the cycle-local rules on every clock:
- the count bound;
- count movement on write, idle read, busy read and empty read;
- zero data on refused reads;
- dropping a write at full with the overrun flag;
- stickiness of that flag.

Arrival order, the wrap of the slot pointers, and the survival of old bytes after an overrun are shown only by the bench. It fills, overruns and drains the buffer and compares each byte against the value it wrote. The register layout is also covered only by the bench.

// File: rtl/irbuf_pkg.sv
package irbuf_pkg;
  parameter int IRBUF_DEPTH    = 18;
  parameter int IRBUF_DATA_W   = 8;
  parameter int IRBUF_PERIOD_W = 10;
  parameter int IRBUF_CFG_W    = 16;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_INC  = 2'b10,
    CNT_DEC  = 2'b01,
    CNT_BOTH = 2'b11
  } cnt_move_e;
endpackage

// File: rtl/irbuf_mem.sv
module irbuf_mem #(
  parameter int DEPTH  = 18,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // Plain synchronous-write, synchronous-read array: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/irbuf_wrap_ptr.sv
module irbuf_wrap_ptr #(
  parameter int N  = 18,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)      ptr_o <= '0;
    else if (adv) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/irbuf_ctrl.sv
module irbuf_ctrl
  import irbuf_pkg::*;
#(
  parameter int DEPTH = 18,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic          wr_stb_i,
  input  logic          rd_stb_i,
  input  logic          ovr_clr_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic          sel_o,
  output logic          ovr_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic      full, empty;
  cnt_move_e move;

  assign full    = (cnt_o == FULL);
  assign empty   = (cnt_o == '0);
  assign wr_ok_o = wr_stb_i && !full;
  assign rd_ok_o = rd_stb_i && !busy_i && !empty;
  assign move    = cnt_move_e'({wr_ok_o, rd_ok_o});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      ovr_o <= 1'b0;
      sel_o <= 1'b0;
    end else begin
      unique case (move)
        CNT_INC:  cnt_o <= cnt_o + 1'b1;
        CNT_DEC:  cnt_o <= cnt_o - 1'b1;
        default:  cnt_o <= cnt_o;
      endcase
      if (wr_stb_i && full)  ovr_o <= 1'b1;
      else if (ovr_clr_i)    ovr_o <= 1'b0;
      if (rd_stb_i)          sel_o <= rd_ok_o;
    end
  end
endmodule

// File: rtl/ir_rx_byte_buf.sv
module ir_rx_byte_buf
  import irbuf_pkg::*;
#(
  parameter int DEPTH    = IRBUF_DEPTH,
  parameter int DATA_W   = IRBUF_DATA_W,
  parameter int PERIOD_W = IRBUF_PERIOD_W,
  parameter int CFG_W    = IRBUF_CFG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busy_i,
  input  logic                wr_stb_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_stb_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                ovr_o,
  input  logic                ovr_clr_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output logic [CFG_W-1:0]    cfg_rdata_o,
  output logic [PERIOD_W-1:0] period_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int RES_W = CFG_W - CW - PERIOD_W;

  logic              wr_ok, rd_ok, sel;
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] mem_q;

  irbuf_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
    .clk(clk), .rst(rst), .busy_i(busy_i), .wr_stb_i(wr_stb_i),
    .rd_stb_i(rd_stb_i), .ovr_clr_i(ovr_clr_i), .wr_ok_o(wr_ok),
    .rd_ok_o(rd_ok), .sel_o(sel), .ovr_o(ovr_o), .cnt_o(cnt)
  );

  irbuf_wrap_ptr #(.N(DEPTH), .AW(AW)) wptr_i (
    .clk(clk), .rst(rst), .adv(wr_ok), .ptr_o(wptr)
  );

  irbuf_wrap_ptr #(.N(DEPTH), .AW(AW)) rptr_i (
    .clk(clk), .rst(rst), .adv(rd_ok), .ptr_o(rptr)
  );

  irbuf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(AW)) mem_i (
    .clk(clk), .we(wr_ok), .waddr(wptr), .wdata(wr_data_i),
    .re(rd_ok), .raddr(rptr), .rdata(mem_q)
  );

  // Refused reads (busy or empty) present zero instead of the RAM output.
  assign rd_data_o = sel ? mem_q : '0;

  always_ff @(posedge clk) begin
    if (rst)           period_o <= '0;
    else if (cfg_wr_i) period_o <= cfg_wdata_i[PERIOD_W-1:0];
  end

  assign cfg_rdata_o = {cnt, {RES_W{1'b0}}, period_o};
endmodule

// File: rtl/ir_rx_byte_buf_chk.sv
module ir_rx_byte_buf_chk #(
  parameter int DEPTH  = 18,
  parameter int DATA_W = 8,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_i,
  input logic              wr_stb_i,
  input logic              rd_stb_i,
  input logic              ovr_clr_i,
  input logic              ovr_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CW-1:0]     cnt
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  p_write_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb_i && !rd_stb_i && cnt < FULL) |=> cnt == $past(cnt) + 1'b1);

  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb_i && cnt == FULL && !(rd_stb_i && !busy_i)) |=> (ovr_o && cnt == FULL));

  p_idle_read_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && !busy_i && cnt != '0 && !wr_stb_i) |=> cnt == $past(cnt) - 1'b1);

  p_busy_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && busy_i && !wr_stb_i) |=> (cnt == $past(cnt) && rd_data_o == '0));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && cnt == '0 && !wr_stb_i) |=> (cnt == '0 && rd_data_o == '0));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(rd_data_o));
endmodule

bind ir_rx_byte_buf ir_rx_byte_buf_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .busy_i(busy_i), .wr_stb_i(wr_stb_i),
  .rd_stb_i(rd_stb_i), .ovr_clr_i(ovr_clr_i), .ovr_o(ovr_o),
  .rd_data_o(rd_data_o), .cnt(cnt)
);

// File: tb/ir_rx_byte_buf_tb_top.sv
module ir_rx_byte_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busy = 1'b0, wr = 1'b0, rd = 1'b0, oclr = 1'b0, cwr = 1'b0;
  logic [7:0]  wdat = '0;
  logic [15:0] cwdat = '0;
  logic [7:0]  rdat;
  logic        ovr;
  logic [15:0] crd;
  logic [9:0]  period;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  ir_rx_byte_buf dut_i (
    .clk(clk), .rst(rst), .busy_i(busy), .wr_stb_i(wr), .wr_data_i(wdat),
    .rd_stb_i(rd), .rd_data_o(rdat), .ovr_o(ovr), .ovr_clr_i(oclr),
    .cfg_wr_i(cwr), .cfg_wdata_i(cwdat), .cfg_rdata_o(crd), .period_o(period)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read, 3 read+write. Inputs set at a falling edge,
  // strobes dropped at the next falling edge; registered results are sampled then.
  task automatic step(input logic [1:0] op, input logic b, input logic [7:0] d);
    @(negedge clk);
    busy = b; wr = op[0]; rd = op[1]; wdat = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  // {op[1:0], busy, wdata[7:0], exp_rdata[7:0], exp_count[4:0], req[3:0]}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {2'd1, 1'b1, 8'hA1, 8'h00, 5'd1, 4'd2},   // R2
    {2'd1, 1'b1, 8'hB2, 8'h00, 5'd2, 4'd2},   // R2
    {2'd1, 1'b1, 8'hC3, 8'h00, 5'd3, 4'd2},   // R2
    {2'd2, 1'b1, 8'h00, 8'h00, 5'd3, 4'd6},   // R6 busy read refused
    {2'd2, 1'b0, 8'h00, 8'hA1, 5'd2, 4'd5},   // R5
    {2'd2, 1'b0, 8'h00, 8'hB2, 5'd1, 4'd5},   // R5
    {2'd2, 1'b0, 8'h00, 8'hC3, 5'd0, 4'd5},   // R5
    {2'd2, 1'b0, 8'h00, 8'h00, 5'd0, 4'd7},   // R7 empty read
    {2'd1, 1'b0, 8'h5A, 8'h00, 5'd1, 4'd11},  // R11 data held across write
    {2'd3, 1'b0, 8'h6B, 8'h5A, 5'd1, 4'd10},  // R10 read+write
    {2'd2, 1'b0, 8'h00, 8'h6B, 5'd0, 4'd5}    // R5
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 count", {11'd0, crd[15:11]}, 16'd0);
    chk("R1 ovr", {15'd0, ovr}, 16'd0);
    chk("R1 rdata", {8'd0, rdat}, 16'd0);
    chk("R1 period", {6'd0, period}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27:26], VEC[i][25], VEC[i][24:17]);
      chk($sformatf("R%0d vec%0d rdata", VEC[i][3:0], i), {8'd0, rdat}, {8'd0, VEC[i][16:9]});
      chk($sformatf("R%0d vec%0d count", VEC[i][3:0], i), {11'd0, crd[15:11]}, {11'd0, VEC[i][8:4]});
    end

    // R2/R3: fill all 18 slots during a frame (pointers wrap past slot 17)
    for (int i = 0; i < 18; i++) step(2'd1, 1'b1, 8'h10 + 8'(i));
    chk("R3 count full", {11'd0, crd[15:11]}, 16'd18);
    chk("R3 no ovr yet", {15'd0, ovr}, 16'd0);
    // R4: 19th byte overruns and is dropped
    step(2'd1, 1'b1, 8'hEE);
    chk("R4 ovr", {15'd0, ovr}, 16'd1);
    chk("R4 count held", {11'd0, crd[15:11]}, 16'd18);
    // R6: busy read at full refused
    step(2'd2, 1'b1, 8'h00);
    chk("R6 busy rdata", {8'd0, rdat}, 16'd0);
    chk("R6 busy count", {11'd0, crd[15:11]}, 16'd18);
    // R5/R4: drain in order, dropped byte absent
    for (int i = 0; i < 18; i++) begin
      step(2'd2, 1'b0, 8'h00);
      chk("R5 drain data", {8'd0, rdat}, {8'd0, 8'h10 + 8'(i)});
      chk("R5 drain count", {11'd0, crd[15:11]}, 16'(17 - i));
    end
    chk("R8 ovr sticky", {15'd0, ovr}, 16'd1);
    step(2'd2, 1'b0, 8'h00);
    chk("R7 empty rdata", {8'd0, rdat}, 16'd0);
    chk("R7 empty count", {11'd0, crd[15:11]}, 16'd0);
    // R8 clear
    @(negedge clk); oclr = 1'b1;
    @(negedge clk); oclr = 1'b0;
    chk("R8 ovr cleared", {15'd0, ovr}, 16'd0);
    // R9 register layout
    @(negedge clk); cwr = 1'b1; cwdat = 16'hFFFF;
    @(negedge clk); cwr = 1'b0;
    chk("R9 cfg readback", crd, 16'h03FF);
    chk("R9 period out", {6'd0, period}, 16'h03FF);
    step(2'd1, 1'b0, 8'h42);
    chk("R9 cfg with count", crd, 16'h0BFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule